// File: doc/BRIEF.md
# Triggered Multi-Mode Sample Buffer

This block holds up to 32 sensor samples of 24 bits each and decides, from a 3-bit mode field, how arriving samples are kept. The modes are:

- **Bypass:** nothing is held.
- **Fill-and-stop:** samples are taken in until the buffer is full, then further samples are dropped.
- **Stream:** when full, each new sample pushes out the oldest.
- **Triggered variants:** a trigger input moves the buffer from bypass or stream into a different behaviour. Stream can become fill-and-stop, and bypass can become either stream or fill-and-stop.

A host drains the buffer one entry per pop. Each pop places the oldest sample on the read word. The stored count is reported together with empty, watermark and overrun flags.

The mode handling is a small state machine with the following states:

| State | Behaviour |
|---|---|
| `ST_OFF` | Bypass. Entered on mode 000 and on the unused codes. |
| `ST_FILL` | Fill-and-stop. |
| `ST_STREAM` | Stream. |
| `ST_ARM_STREAM` | Streaming, waiting for a trigger. |
| `ST_ARM_BYP_S` | Bypassing, waiting for a trigger, then stream. |
| `ST_ARM_BYP_F` | Bypassing, waiting for a trigger, then fill-and-stop. |

The state machine has these transitions:

- **Mode entry:** taken whenever the mode field differs from the previously accepted one. It goes to the entry state of the new mode: 001→`ST_FILL`, 010→`ST_STREAM`, 011→`ST_ARM_STREAM`, 100→`ST_ARM_BYP_S`, 111→`ST_ARM_BYP_F`.
- **Flush:** any enabled cycle with a bypass code goes to `ST_OFF`.
- **Trigger moves:** `ST_ARM_STREAM`→`ST_FILL`, `ST_ARM_BYP_S`→`ST_STREAM`, and `ST_ARM_BYP_F`→`ST_FILL`.

Top module: `trig_sample_fifo`

## Requirements
- R1: Capacity is 32 entries of 24 bits. `count` reports 0 to 32 entries, and `empty` is 1 exactly when `count` is 0. After reset the buffer is empty, both flags are 0 and `rd_data` is 0.
- R2: Mode code 000, and the unused codes 101 and 110, mean bypass. In bypass no sample is stored. Any enabled cycle in bypass discards all entries and clears the overrun flag.
- R3: Mode 001 (fill-and-stop) stores samples until the depth limit is reached. Later samples are dropped and the overrun flag is not set.
- R4: Mode 010 (stream) stores samples up to the depth limit. After that, each new sample is stored and the oldest entry is discarded.
- R5: Mode 011 streams until a trigger, then behaves as fill-and-stop. Entries held at the trigger are kept.
- R6: Mode 100 stores nothing until a trigger, then streams.
- R7: Mode 111 stores nothing until a trigger, then fills and stops.
- R8: A pop when the buffer is not empty loads the oldest entry into `rd_data` at the next clock edge and lowers `count` by one. A pop when the buffer is empty changes nothing.
- R9: `wm_flag` is 1 when `wm_level` is non-zero and `count` is at least `wm_level`. With `wm_level` at 0 the flag is 0.
- R10: With `stop_on_wm` at 1 and a non-zero `wm_level`, the depth limit used by R3 and R4 is `wm_level` instead of 32.
- R11: `ovr_flag` sets when a sample discards the oldest entry. It clears on the next successful pop.
- R12: While `en` is 0, the block ignores samples, pops, mode changes and triggers. Contents, count, flags and `rd_data` hold.
- R13: A new mode code or a trigger takes effect from the following clock edge. A sample presented in the same cycle is handled under the previous behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Buffer enable |
| mode | input | 3 | Mode select code |
| trig | input | 1 | Trigger event (interrupt-active) |
| stop_on_wm | input | 1 | Limit depth to the watermark level |
| wm_level | input | 5 | Watermark level |
| smp_valid | input | 1 | New sample strobe |
| smp_data | input | 24 | Sample value |
| rd_pop | input | 1 | Pop the oldest entry |
| rd_data | output | 24 | Last popped sample |
| count | output | 6 | Number of stored entries |
| wm_flag | output | 1 | Watermark reached |
| ovr_flag | output | 1 | Oldest entry was overwritten |
| empty | output | 1 | No stored entries |

## Verification
The properties assume that every input is stable around the rising edge and that `rst_n` starts low. The pop-related properties assume no sample arrives in the same cycle as the pop, because a simultaneous push could keep the count level or re-raise the overrun flag. The decrement property further assumes the mode field holds a defined non-bypass code. The directed tests drive all inputs on the falling edge and never combine a pop with a sample in one cycle. They also keep the mode field steady while the pop checks run.

// File: rtl/trig_fifo_pkg.sv
package trig_fifo_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_FILL,
        ST_STREAM,
        ST_ARM_STREAM,
        ST_ARM_BYP_S,
        ST_ARM_BYP_F
    } fifo_state_t;

    localparam logic [2:0] MD_BYPASS   = 3'b000;
    localparam logic [2:0] MD_FILL     = 3'b001;
    localparam logic [2:0] MD_STREAM   = 3'b010;
    localparam logic [2:0] MD_STR2FILL = 3'b011;
    localparam logic [2:0] MD_BYP2STR  = 3'b100;
    localparam logic [2:0] MD_BYP2FILL = 3'b111;

    // State entered when a mode code is newly accepted; unused codes act as bypass.
    function automatic fifo_state_t entry_state(input logic [2:0] m);
        case (m)
            MD_FILL:     return ST_FILL;
            MD_STREAM:   return ST_STREAM;
            MD_STR2FILL: return ST_ARM_STREAM;
            MD_BYP2STR:  return ST_ARM_BYP_S;
            MD_BYP2FILL: return ST_ARM_BYP_F;
            default:     return ST_OFF;
        endcase
    endfunction

endpackage

// File: rtl/trig_fifo_ctrl.sv
module trig_fifo_ctrl
    import trig_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [2:0]  mode,
    input  logic        trig,
    output fifo_state_t state,
    output logic        accept,
    output logic        may_discard,
    output logic        flush
);

    fifo_state_t state_q, state_d;
    logic [2:0]  mode_q;
    logic        is_bypass;

    assign is_bypass = (entry_state(mode) == ST_OFF);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            mode_q  <= MD_BYPASS;
        end else if (en) begin
            state_q <= state_d;
            mode_q  <= mode;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (is_bypass) begin
            state_d = ST_OFF;
        end else if (mode != mode_q) begin
            state_d = entry_state(mode);
        end else begin
            unique case (state_q)
                ST_ARM_STREAM: if (trig) state_d = ST_FILL;
                ST_ARM_BYP_S:  if (trig) state_d = ST_STREAM;
                ST_ARM_BYP_F:  if (trig) state_d = ST_FILL;
                ST_OFF, ST_FILL, ST_STREAM: state_d = state_q;
                default:       state_d = ST_OFF;
            endcase
        end
    end

    // Per-state outputs
    always_comb begin
        accept      = 1'b0;
        may_discard = 1'b0;
        unique case (state_q)
            ST_FILL:       accept = 1'b1;
            ST_STREAM,
            ST_ARM_STREAM: begin
                accept      = 1'b1;
                may_discard = 1'b1;
            end
            ST_OFF, ST_ARM_BYP_S, ST_ARM_BYP_F: accept = 1'b0;
            default:       accept = 1'b0;
        endcase
        flush = en && is_bypass;
    end

    assign state = state_q;

endmodule

// File: rtl/trig_fifo_store.sv
module trig_fifo_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 24,
    parameter int LVLW  = 5,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            flush,
    input  logic            accept,
    input  logic            may_discard,
    input  logic            stop_on_wm,
    input  logic [LVLW-1:0] wm_level,
    input  logic            smp_valid,
    input  logic [DW-1:0]   smp_data,
    input  logic            rd_pop,
    output logic [DW-1:0]   rd_data,
    output logic [CW-1:0]   count,
    output logic            wm_flag,
    output logic            ovr_flag,
    output logic            empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q, limit, after_pop;
    logic          pop, wr, disc, room, ovr_q;

    assign limit     = (stop_on_wm && wm_level != '0) ? CW'(wm_level) : CW'(DEPTH);
    assign pop       = en && !flush && rd_pop && (cnt_q != '0);
    assign after_pop = cnt_q - CW'(pop);
    assign room      = after_pop < limit;
    assign wr        = en && !flush && accept && smp_valid && (room || may_discard);
    assign disc      = wr && !room;

    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= smp_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt_q   <= '0;
            ovr_q   <= 1'b0;
            rd_data <= '0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (pop) rd_data <= mem[rd_ptr];
            wr_ptr <= wr_ptr + AW'(wr);
            rd_ptr <= rd_ptr + AW'(pop) + AW'(disc);
            cnt_q  <= cnt_q + CW'(wr) - CW'(pop) - CW'(disc);
            if (disc)     ovr_q <= 1'b1;
            else if (pop) ovr_q <= 1'b0;
        end
    end

    assign count    = cnt_q;
    assign empty    = (cnt_q == '0);
    assign ovr_flag = ovr_q;
    assign wm_flag  = (wm_level != '0) && (cnt_q >= CW'(wm_level));

endmodule

// File: rtl/trig_sample_fifo.sv
module trig_sample_fifo
    import trig_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 24,
    parameter int LVLW  = 5,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [2:0]      mode,
    input  logic            trig,
    input  logic            stop_on_wm,
    input  logic [LVLW-1:0] wm_level,
    input  logic            smp_valid,
    input  logic [DW-1:0]   smp_data,
    input  logic            rd_pop,
    output logic [DW-1:0]   rd_data,
    output logic [CW-1:0]   count,
    output logic            wm_flag,
    output logic            ovr_flag,
    output logic            empty
);

    fifo_state_t state;
    logic        accept, may_discard, flush;

    trig_fifo_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .mode        (mode),
        .trig        (trig),
        .state       (state),
        .accept      (accept),
        .may_discard (may_discard),
        .flush       (flush)
    );

    trig_fifo_store #(
        .DEPTH (DEPTH),
        .DW    (DW),
        .LVLW  (LVLW)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .flush       (flush),
        .accept      (accept),
        .may_discard (may_discard),
        .stop_on_wm  (stop_on_wm),
        .wm_level    (wm_level),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .rd_pop      (rd_pop),
        .rd_data     (rd_data),
        .count       (count),
        .wm_flag     (wm_flag),
        .ovr_flag    (ovr_flag),
        .empty       (empty)
    );

endmodule

// File: rtl/trig_fifo_checker.sv
module trig_fifo_checker #(
    parameter int DEPTH = 32,
    parameter int DW    = 24,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [2:0]    mode,
    input logic          smp_valid,
    input logic          rd_pop,
    input logic [DW-1:0] rd_data,
    input logic [CW-1:0] count,
    input logic          ovr_flag,
    input logic          empty
);

    logic defined_mode;
    assign defined_mode = (mode == 3'b001) || (mode == 3'b010) || (mode == 3'b011) ||
                          (mode == 3'b100) || (mode == 3'b111);

    // R1
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2
    a_r2_bypass_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 3'b000) |=> (empty && !ovr_flag));

    // R8
    a_r8_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_pop && !empty && !smp_valid && defined_mode) |=> (count == $past(count) - 1'b1));

    // R11
    a_r11_ovr_clear_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_pop && !empty && !smp_valid) |=> !ovr_flag);

    // R12
    a_r12_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(count) && $stable(rd_data) && $stable(ovr_flag)));

endmodule

bind trig_sample_fifo trig_fifo_checker #(
    .DEPTH (DEPTH),
    .DW    (DW),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode      (mode),
    .smp_valid (smp_valid),
    .rd_pop    (rd_pop),
    .rd_data   (rd_data),
    .count     (count),
    .ovr_flag  (ovr_flag),
    .empty     (empty)
);

// File: tb/trig_sample_fifo_test.sv
module trig_sample_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic        trig = 1'b0;
    logic        stop_on_wm = 1'b0;
    logic [4:0]  wm_level = 5'd0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic        rd_pop = 1'b0;
    logic [23:0] rd_data;
    logic [5:0]  count;
    logic        wm_flag, ovr_flag, empty;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trig_sample_fifo uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .trig(trig),
        .stop_on_wm(stop_on_wm), .wm_level(wm_level), .smp_valid(smp_valid),
        .smp_data(smp_data), .rd_pop(rd_pop), .rd_data(rd_data), .count(count),
        .wm_flag(wm_flag), .ovr_flag(ovr_flag), .empty(empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk); mode = m;
        @(negedge clk);
    endtask

    task automatic push_n(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); smp_valid = 1'b1; smp_data = 24'(base + i);
        end
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic pop_one();
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
    endtask

    task automatic trig_pulse();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset count", count, 0);
        chk("R1 reset empty", empty, 1);
        chk("R1 reset ovr", ovr_flag, 0);
        chk("R1 reset wm", wm_flag, 0);
        chk("R1 reset rd_data", rd_data, 0);
    endtask

    task automatic t_fill();
        set_mode(3'b001);
        push_n(34, 1000);
        chk("R3 fill count at full", count, 32);
        chk("R3 fill no overrun", ovr_flag, 0);
        for (int i = 0; i < 32; i++) begin
            pop_one();
            chk("R8 fill pop order", rd_data, 1000 + i);
        end
        chk("R1 empty after drain", empty, 1);
        pop_one();
        chk("R8 pop on empty data", rd_data, 1031);
        chk("R8 pop on empty count", count, 0);
    endtask

    task automatic t_stream();
        set_mode(3'b000);
        set_mode(3'b010);
        push_n(35, 2000);
        chk("R4 stream count", count, 32);
        chk("R11 overrun set", ovr_flag, 1);
        pop_one();
        chk("R4 stream oldest survivor", rd_data, 2003);
        chk("R11 overrun cleared by pop", ovr_flag, 0);
        chk("R8 count after pop", count, 31);
        set_mode(3'b000);
        chk("R2 flush to empty", count, 0);
    endtask

    task automatic t_watermark();
        set_mode(3'b001);
        wm_level = 5'd5;
        push_n(4, 3000);
        chk("R9 below watermark", wm_flag, 0);
        push_n(1, 3004);
        chk("R9 at watermark", wm_flag, 1);
        stop_on_wm = 1'b1;
        push_n(1, 3005);
        chk("R10 fill limited by watermark", count, 5);
        chk("R3 no overrun at limit", ovr_flag, 0);
        set_mode(3'b010);
        push_n(2, 4000);
        chk("R10 stream limited count", count, 5);
        chk("R11 stream overrun at limit", ovr_flag, 1);
        pop_one();
        chk("R10 oldest after limited discard", rd_data, 3002);
        stop_on_wm = 1'b0;
        wm_level = 5'd0;
        chk("R9 zero level disables flag", wm_flag, 0);
        set_mode(3'b000);
    endtask

    task automatic t_stream_to_fill();
        set_mode(3'b011);
        push_n(3, 5000);
        chk("R5 streaming before trigger", count, 3);
        trig_pulse();
        push_n(40, 5100);
        chk("R5 full after trigger", count, 32);
        chk("R5 no discard after trigger", ovr_flag, 0);
        pop_one();
        chk("R5 pre-trigger entries kept", rd_data, 5000);
        set_mode(3'b000);
    endtask

    task automatic t_bypass_to_stream();
        set_mode(3'b100);
        push_n(3, 6500);
        chk("R6 nothing stored before trigger", count, 0);
        trig_pulse();
        push_n(34, 6000);
        chk("R6 stream count", count, 32);
        chk("R6 overrun in stream", ovr_flag, 1);
        pop_one();
        chk("R6 oldest survivor", rd_data, 6002);
        set_mode(3'b000);
    endtask

    task automatic t_bypass_to_fill();
        set_mode(3'b111);
        push_n(2, 7500);
        chk("R7 nothing stored before trigger", count, 0);
        @(negedge clk); smp_valid = 1'b1; smp_data = 24'd7777; trig = 1'b1;
        @(negedge clk); smp_valid = 1'b0; trig = 1'b0;
        chk("R13 sample with trigger uses old behaviour", count, 0);
        push_n(33, 7000);
        chk("R7 fill count", count, 32);
        chk("R7 no overrun", ovr_flag, 0);
        pop_one();
        chk("R7 first post-trigger sample", rd_data, 7000);
    endtask

    task automatic t_enable();
        en = 1'b0;
        push_n(1, 8000);
        chk("R12 disabled push ignored", count, 31);
        pop_one();
        chk("R12 disabled pop data held", rd_data, 7000);
        chk("R12 disabled pop count held", count, 31);
        set_mode(3'b000);
        chk("R12 disabled mode change ignored", count, 31);
        @(negedge clk); en = 1'b1;
        @(negedge clk);
        chk("R2 flush after enable", count, 0);
        chk("R2 empty after flush", empty, 1);
    endtask

    task automatic t_reserved();
        set_mode(3'b101);
        push_n(2, 9000);
        chk("R2 reserved code stores nothing", count, 0);
        set_mode(3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        en = 1'b1;
        t_fill();
        t_stream();
        t_watermark();
        t_stream_to_fill();
        t_bypass_to_stream();
        t_bypass_to_fill();
        t_enable();
        t_reserved();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule